// File: doc/BRIEF.md
# Address-Decoded Parallel Port Bridge

This block sits between a simple processor bus and a bank of parallel ports: several 8-bit input sources and the same number of 8-bit output registers. The bus is modelled with an address, a read strobe, a write strobe, an I/O-versus-memory qualifier, and a data path split into input data, output data and an output-enable flag. The flag stands for the point where a tri-state driver would let the port's data onto the shared bus.

A port is selected only when two things hold at once: the address falls in the port's space, and the strobe for the right kind of cycle is active. One of two address-space styles is chosen at build time. In the memory-mapped style, the top 1 KiB of a 16-bit space (0xFC00 and up) is reserved for I/O, so the full address is decoded. In the separate-space style, a qualifier input marks I/O cycles, and only the low address byte is decoded.

Read data reaches the bus without delay while a matching read is held. A write is taken into the selected output register on the first clock edge that sees the write strobe high. The output registers can be cleared together by a clear input or by reset.

Top module: `pio_port_if`

## Requirements
- R1: In memory-mapped mode, the block responds only when address bits [15:10] are all ones. Addresses 0x0000 to 0xFBFF never enable the bus driver and never change an output register.
- R2: In separate-space mode, the block responds only while `io_m_i` is 1. Address bits [15:8] are ignored, and in that mode the decoded offset is bits [7:0].
- R3: Address bits [1:0] pick port 0 to 3. A port is mapped only when the decoded offset bits above bit 1 are all zero (bits [9:2] in memory-mapped mode, bits [7:2] in separate-space mode).
- R4: `bus_doe_o` is 1 only while `rd_i` is 1 and the address is in the I/O space. While `bus_doe_o` is 0, `bus_dout_o` is 0x00.
- R5: During a read of a mapped port, `bus_dout_o` equals that port's byte of `src_data_i` (port n at bits [8n+7:8n]) in the same cycle.
- R6: A write is captured on the first rising clock edge at which `wr_i` is 1 after being 0 at the previous edge. It writes `bus_din_i` into the addressed register only. Holding `wr_i` high for further edges writes nothing more.
- R7: An in-space address with a non-zero offset above bit 1 reads 0x00 with `bus_doe_o` high, and a write to it changes no register.
- R8: `latch_clr_i` high at a clock edge zeroes every output register, and it takes priority over a write in the same cycle.
- R9: `rst_n` low zeroes every output register at once, without waiting for a clock edge.
- R10: A write to one port leaves the other output registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| io_m_i | input | 1 | 1 = I/O cycle, 0 = memory cycle (separate-space mode only) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| bus_din_i | input | 8 | Write data from the bus |
| bus_dout_o | output | 8 | Read data toward the bus |
| bus_doe_o | output | 1 | Bus drive enable (0 = high impedance) |
| src_data_i | input | 32 | Four input sources, port n at [8n+7:8n] |
| latch_clr_i | input | 1 | Synchronous clear of all output registers |
| latch_q_o | output | 32 | Four output registers, port n at [8n+7:8n] |

## Verification
Every read pattern uses four distinct source bytes, so a wrong port index shows up as a wrong value. Addresses just inside and just outside the 0xFC00 boundary, and an address with only bit 15 clear, show whether the full upper field is decoded. In-space addresses with non-zero offset bits separate mapped from unmapped decode. A write held across several edges while its data changes tells edge capture apart from level capture. A write issued together with a clear shows which of the two wins. A second instance in separate-space mode is driven with garbage in the upper address byte and with the qualifier both high and low.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic {
    DEC_MEM_MAPPED = 1'b0,
    DEC_SEPARATE   = 1'b1
  } dec_mode_e;

endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter dec_mode_e MODE     = DEC_MEM_MAPPED,
  parameter int        ADDR_W   = 16,
  parameter int        WIN_BITS = 6,
  parameter int        IO_DEC_W = 8,
  parameter int        SEL_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_m_i,
  output logic              hit_o,
  output logic              mapped_o,
  output logic [SEL_W-1:0]  idx_o
);

  localparam int OFF_TOP_MM  = ADDR_W - WIN_BITS - 1;
  localparam int OFF_TOP_SEP = IO_DEC_W - 1;

  logic unused_bits;
  assign unused_bits = ^{addr_i, io_m_i};

  assign idx_o = addr_i[SEL_W-1:0];

  generate
    if (MODE == DEC_MEM_MAPPED) begin : g_mm
      assign hit_o    = &addr_i[ADDR_W-1 -: WIN_BITS];
      assign mapped_o = (addr_i[OFF_TOP_MM:SEL_W] == '0);
    end else begin : g_sep
      assign hit_o    = io_m_i;
      assign mapped_o = (addr_i[OFF_TOP_SEP:SEL_W] == '0);
    end
  endgenerate

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2
) (
  input  logic                        rd_i,
  input  logic                        hit_i,
  input  logic                        mapped_i,
  input  logic [SEL_W-1:0]            idx_i,
  input  logic [NUM_PORTS*DATA_W-1:0] src_i,
  output logic                        doe_o,
  output logic [DATA_W-1:0]           dout_o
);

  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx_i == SEL_W'(p)) sel_data = src_i[p*DATA_W +: DATA_W];
    end
  end

  assign doe_o  = rd_i & hit_i;
  assign dout_o = (doe_o && mapped_i) ? sel_data : '0;

endmodule

// File: rtl/pio_wr_ctrl.sv
module pio_wr_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 hit_i,
  input  logic                 mapped_i,
  input  logic [SEL_W-1:0]     idx_i,
  output logic [NUM_PORTS-1:0] we_o
);

  logic wr_q, wr_d;
  logic wr_pulse;

  assign wr_d     = wr_i;
  assign wr_pulse = wr_i & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_we
      assign we_o[p] = wr_pulse & hit_i & mapped_i & (idx_i == SEL_W'(p));
    end
  endgenerate

  // R6: at most one register written per strobe, never on back-to-back edges
  a_r6_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_o));
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_o) |=> (we_o == '0));

endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i)     q_d = '0;
    else if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_o == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/pio_port_if.sv
module pio_port_if
  import pio_pkg::*;
#(
  parameter dec_mode_e MODE      = DEC_MEM_MAPPED,
  parameter int        ADDR_W    = 16,
  parameter int        DATA_W    = 8,
  parameter int        NUM_PORTS = 4,
  parameter int        WIN_BITS  = 6,
  parameter int        IO_DEC_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        io_m_i,
  input  logic                        rd_i,
  input  logic                        wr_i,
  input  logic [DATA_W-1:0]           bus_din_i,
  output logic [DATA_W-1:0]           bus_dout_o,
  output logic                        bus_doe_o,
  input  logic [NUM_PORTS*DATA_W-1:0] src_data_i,
  input  logic                        latch_clr_i,
  output logic [NUM_PORTS*DATA_W-1:0] latch_q_o
);

  localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic             hit, mapped;
  logic [SEL_W-1:0] idx;
  logic [NUM_PORTS-1:0] we;

  pio_addr_decode #(
    .MODE(MODE), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
    .IO_DEC_W(IO_DEC_W), .SEL_W(SEL_W)
  ) u_dec (
    .addr_i(addr_i), .io_m_i(io_m_i),
    .hit_o(hit), .mapped_o(mapped), .idx_o(idx)
  );

  pio_rd_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rd (
    .rd_i(rd_i), .hit_i(hit), .mapped_i(mapped), .idx_i(idx),
    .src_i(src_data_i), .doe_o(bus_doe_o), .dout_o(bus_dout_o)
  );

  pio_wr_ctrl #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .hit_i(hit),
    .mapped_i(mapped), .idx_i(idx), .we_o(we)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lat
      pio_out_latch #(.DATA_W(DATA_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .clr_i(latch_clr_i), .we_i(we[p]),
        .d_i(bus_din_i), .q_o(latch_q_o[p*DATA_W +: DATA_W])
      );
    end
  endgenerate

  a_r4_doe_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe_o |-> rd_i);
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe_o |-> (bus_dout_o == '0));
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe_o && !mapped) |-> (bus_dout_o == '0));
  a_r7_unmapped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (we == '0));

  generate
    if (MODE == DEC_SEPARATE) begin : g_chk_sep
      a_r2_doe_needs_iom: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe_o |-> io_m_i);
      a_r2_we_needs_iom: assert property (@(posedge clk) disable iff (!rst_n)
        (|we) |-> io_m_i);
    end else begin : g_chk_mm
      a_r1_window_top: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe_o || (|we)) |-> (&addr_i[ADDR_W-1 -: WIN_BITS]));
    end
  endgenerate

endmodule

// File: tb/pio_port_if_tb_top.sv
`timescale 1ns/1ps
module pio_port_if_tb_top;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        io_m, rd, wr, clr;
  logic [7:0]  din;
  logic [31:0] src;
  logic [7:0]  dout_mm, dout_sp;
  logic        doe_mm, doe_sp;
  logic [31:0] q_mm, q_sp;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pio_port_if #(.MODE(DEC_MEM_MAPPED)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .io_m_i(io_m), .rd_i(rd),
    .wr_i(wr), .bus_din_i(din), .bus_dout_o(dout_mm), .bus_doe_o(doe_mm),
    .src_data_i(src), .latch_clr_i(clr), .latch_q_o(q_mm)
  );

  pio_port_if #(.MODE(DEC_SEPARATE)) dut_sep_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .io_m_i(io_m), .rd_i(rd),
    .wr_i(wr), .bus_din_i(din), .bus_dout_o(dout_sp), .bus_doe_o(doe_sp),
    .src_data_i(src), .latch_clr_i(clr), .latch_q_o(q_sp)
  );

  // {addr, rd, expected doe, expected dout}
  localparam int NV = 10;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {16'hFC00, 1'b1, 1'b1, 8'hA1},  // R3 R5 port 0
    {16'hFC01, 1'b1, 1'b1, 8'hB2},  // R5 port 1
    {16'hFC02, 1'b1, 1'b1, 8'hC3},  // R5 port 2
    {16'hFC03, 1'b1, 1'b1, 8'hD4},  // R5 port 3
    {16'hFC04, 1'b1, 1'b1, 8'h00},  // R7 unmapped
    {16'hFFFF, 1'b1, 1'b1, 8'h00},  // R7 top of space
    {16'hFBFF, 1'b1, 1'b0, 8'h00},  // R1 just below space
    {16'h7C00, 1'b1, 1'b0, 8'h00},  // R1 bit 15 clear
    {16'h0000, 1'b1, 1'b0, 8'h00},  // R1 memory
    {16'hFC01, 1'b0, 1'b0, 8'h00}   // R4 no strobe
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    addr = a; din = d; wr = 1'b1; clr = c;
    @(negedge clk);
    wr = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; io_m = 1'b0; rd = 1'b0; wr = 1'b0;
    clr = 1'b0; din = '0; src = 32'hD4C3B2A1;
    repeat (3) @(negedge clk);
    check("R9 reset mm", q_mm, 32'h0);
    check("R9 reset sep", q_sp, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][25:10]; rd = VEC[i][9];
      #1;
      check("R1/R4/R5/R7 read doe", {31'b0, doe_mm}, {31'b0, VEC[i][8]});
      check("R1/R4/R5/R7 read data", {24'b0, dout_mm}, {24'b0, VEC[i][7:0]});
    end
    rd = 1'b0;

    // R6 R10 single write
    do_write(16'hFC01, 8'h5A, 1'b0);
    check("R6 R10 write port1", q_mm, 32'h00005A00);

    // R6 held strobe: no second capture
    @(negedge clk); addr = 16'hFC01; din = 8'h11; wr = 1'b1;
    @(negedge clk); din = 8'h77;
    @(negedge clk); din = 8'h88;
    @(negedge clk);
    check("R6 held strobe", q_mm, 32'h00001100);
    wr = 1'b0;
    @(negedge clk);

    do_write(16'hFBFF, 8'h33, 1'b0);
    check("R1 write below space", q_mm, 32'h00001100);
    do_write(16'hFC05, 8'h44, 1'b0);
    check("R7 unmapped write", q_mm, 32'h00001100);
    do_write(16'hFC03, 8'hE7, 1'b0);
    check("R10 write port3", q_mm, 32'hE7001100);

    do_write(16'hFC00, 8'h66, 1'b1);
    check("R8 clear beats write", q_mm, 32'h0);

    do_write(16'hFC02, 8'h99, 1'b0);
    check("R10 write port2", q_mm, 32'h00990000);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R8 clear alone", q_mm, 32'h0);

    do_write(16'hFC03, 8'h3C, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 async reset", q_mm, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // separate-space instance
    @(negedge clk); addr = 16'h1203; io_m = 1'b1; rd = 1'b1; #1;
    check("R2 sep read doe", {31'b0, doe_sp}, 32'h1);
    check("R2 sep read data", {24'b0, dout_sp}, 32'hD4);
    @(negedge clk); io_m = 1'b0; #1;
    check("R2 sep iom low", {31'b0, doe_sp}, 32'h0);
    @(negedge clk); addr = 16'h0004; io_m = 1'b1; #1;
    check("R7 sep unmapped doe", {31'b0, doe_sp}, 32'h1);
    check("R7 sep unmapped data", {24'b0, dout_sp}, 32'h0);
    rd = 1'b0; io_m = 1'b0;
    do_write(16'h0002, 8'h5E, 1'b0);
    check("R2 sep write iom low", q_sp, 32'h0);
    io_m = 1'b1;
    do_write(16'hAB02, 8'h5E, 1'b0);
    check("R2 sep write upper ignored", q_sp, 32'h005E0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule